// File: doc/BRIEF.md
# Eight-bit multicycle register/stack processor core

This core runs small programs out of a 256-byte memory that sits outside it. It reads one byte per cycle through a single memory port with combinational read data. Each instruction starts with an opcode byte and is followed by zero, one or two operand bytes. The top two bits of the opcode give the number of operand bytes. The core then executes the instruction against eight 8-bit registers, and register 7 also serves as a downward-growing stack pointer.

The instruction set is small: load an immediate value into a register, emit a register on an output strobe, multiply two registers, push a register onto the stack, pop the stack into a register, and stop. A program is placed in memory while reset is held. After reset is released, the core runs until it stops. It stops either on the stop instruction, or with an illegal-instruction flag when it meets an opcode it does not recognise.

Top module: `cpu8_core`

## Requirements
- R1: After reset the program counter is 0, so the first fetch presents address 0 on `mem_addr`. `halted`, `illegal`, `out_valid` and `mem_we` are low, and register 7 holds 0xF4.
- R2: Opcode values are: stop 0x01, load-immediate 0x82, emit 0x47, multiply 0xA2, push 0x45, pop 0x46. Opcode bits [7:6] give the operand byte count N, and the program counter advances by N+1 after each retired instruction.
- R3: Load-immediate (0x82, rX, imm) writes imm into register rX.
- R4: Emit (0x47, rX) drives register rX on `out_data` with `out_valid` high for exactly one cycle.
- R5: Multiply (0xA2, rA, rB) writes the low 8 bits of rA*rB into rA.
- R6: Push (0x45, rX) first decrements register 7, modulo 256. It then writes rX to memory at the new register 7 value.
- R7: Pop (0x46, rX) loads memory at register 7 into rX and then increments register 7, modulo 256.
- R8: Stop (0x01) raises `halted`, which stays high until reset. After that there are no memory writes, no emits, and `mem_addr` does not change.
- R9: Any other opcode raises both `illegal` and `halted`. No later instruction executes.
- R10: Only bits [2:0] of a register operand byte select the register; the upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 8 | Memory address for read or write |
| mem_wdata | output | 8 | Data to write on a push |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |
| out_valid | output | 1 | One-cycle strobe for an emitted value |
| out_data | output | 8 | Emitted register value |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Core stopped on an unknown opcode |

## Verification
The bench builds the core with its default parameters: eight registers, register 7 as stack pointer, and a stack pointer reset value of 0xF4. With these values an unpreloaded first push lands at 0xF3. The values also let a program reload register 7 with 0x00, so that a push wraps the pointer to 0xFF and the matching pop wraps it back to 0x00 within a few instructions. Multiply operands whose products exceed 255 exercise truncation. Register operand bytes with upper bits set exercise the 3-bit register field.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

  localparam int WORD_W = 8;
  localparam int ADDR_W = 8;

  localparam logic [WORD_W-1:0] OPC_STOP = 8'h01;
  localparam logic [WORD_W-1:0] OPC_LDI  = 8'h82;
  localparam logic [WORD_W-1:0] OPC_EMIT = 8'h47;
  localparam logic [WORD_W-1:0] OPC_MUL  = 8'hA2;
  localparam logic [WORD_W-1:0] OPC_PUSH = 8'h45;
  localparam logic [WORD_W-1:0] OPC_POP  = 8'h46;

  typedef enum logic [2:0] {
    K_STOP, K_LDI, K_EMIT, K_MUL, K_PUSH, K_POP, K_BAD
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_FETCH, ST_OPA, ST_OPB, ST_EXEC, ST_STACK, ST_HALT
  } state_e;

  // operand byte count carried in the opcode's top two bits
  function automatic logic [1:0] opnd_count(input logic [1:0] top_bits);
    return top_bits;
  endfunction

  // program counter step: one opcode byte plus its operand bytes
  function automatic logic [ADDR_W-1:0] pc_step(input logic [WORD_W-1:0] opc);
    return {{(ADDR_W-2){1'b0}}, opnd_count(opc[7:6])} + ADDR_W'(1);
  endfunction

  // product truncated to the word width
  function automatic logic [WORD_W-1:0] mul_lo(input logic [WORD_W-1:0] a,
                                               input logic [WORD_W-1:0] b);
    return a * b;
  endfunction

  function automatic logic [ADDR_W-1:0] sp_dec(input logic [ADDR_W-1:0] sp);
    return sp - ADDR_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] sp_inc(input logic [ADDR_W-1:0] sp);
    return sp + ADDR_W'(1);
  endfunction

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
  import cpu8_pkg::*;
(
  input  logic [WORD_W-1:0] opcode,
  output op_kind_e          kind,
  output logic              legal,
  output logic              stops,
  output logic              uses_stack
);

  always_comb begin
    unique case (opcode)
      OPC_STOP: kind = K_STOP;
      OPC_LDI:  kind = K_LDI;
      OPC_EMIT: kind = K_EMIT;
      OPC_MUL:  kind = K_MUL;
      OPC_PUSH: kind = K_PUSH;
      OPC_POP:  kind = K_POP;
      default:  kind = K_BAD;
    endcase
  end

  assign legal      = (kind != K_BAD);
  assign stops      = (kind == K_STOP) || (kind == K_BAD);
  assign uses_stack = (kind == K_PUSH) || (kind == K_POP);

endmodule

// File: rtl/cpu8_regfile.sv
module cpu8_regfile
  import cpu8_pkg::*;
#(
  parameter int                NUM_REGS = 8,
  parameter int                SP_INDEX = 7,
  parameter logic [WORD_W-1:0] SP_RESET = 8'hF4,
  localparam int               RW       = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [RW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [RW-1:0]     raddr_a,
  input  logic [RW-1:0]     raddr_b,
  output logic [WORD_W-1:0] rdata_a,
  output logic [WORD_W-1:0] rdata_b,
  output logic [WORD_W-1:0] sp_val
);

  logic [WORD_W-1:0] rf [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [WORD_W-1:0] RST_V = (g == SP_INDEX) ? SP_RESET : '0;
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= RST_V;
      end else if (we && (waddr == RW'(g))) begin
        q <= wdata;
      end
    end
    assign rf[g] = q;
  end

  assign rdata_a = rf[raddr_a];
  assign rdata_b = rf[raddr_b];
  assign sp_val  = rf[SP_INDEX];

endmodule

// File: rtl/cpu8_seq.sv
module cpu8_seq
  import cpu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] fetched_top,
  input  logic [1:0] ir_top,
  input  logic       ir_stops,
  input  logic       ir_stack,
  output state_e     state
);

  state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_FETCH: nxt = (opnd_count(fetched_top) == 2'd0) ? ST_EXEC : ST_OPA;
      ST_OPA:   nxt = (opnd_count(ir_top) >= 2'd2) ? ST_OPB : ST_EXEC;
      ST_OPB:   nxt = ST_EXEC;
      ST_EXEC: begin
        if (ir_stops)      nxt = ST_HALT;
        else if (ir_stack) nxt = ST_STACK;
        else               nxt = ST_FETCH;
      end
      ST_STACK: nxt = ST_FETCH;
      ST_HALT:  nxt = ST_HALT;
      default:  nxt = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
  import cpu8_pkg::*;
#(
  parameter int                NUM_REGS = 8,
  parameter int                SP_INDEX = 7,
  parameter logic [WORD_W-1:0] SP_RESET = 8'hF4
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              halted,
  output logic              illegal
);

  localparam int RW = $clog2(NUM_REGS);
  localparam logic [RW-1:0] SP_SEL = RW'(SP_INDEX);

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [WORD_W-1:0] ir_q;
  logic [RW-1:0]     ra_q;
  logic [WORD_W-1:0] opb_q;

  op_kind_e kind;
  logic     ir_legal, ir_stops, ir_stack;

  logic              rf_we;
  logic [RW-1:0]     rf_waddr;
  logic [WORD_W-1:0] rf_wdata, rd_a, rd_b, sp_val;

  // named internal events for the checker
  logic ev_fetch, ev_retire, ev_push_wr, ev_pop_rd;

  cpu8_decode u_dec (
    .opcode     (ir_q),
    .kind       (kind),
    .legal      (ir_legal),
    .stops      (ir_stops),
    .uses_stack (ir_stack)
  );

  cpu8_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetched_top (mem_rdata[7:6]),
    .ir_top      (ir_q[7:6]),
    .ir_stops    (ir_stops),
    .ir_stack    (ir_stack),
    .state       (state_q)
  );

  cpu8_regfile #(
    .NUM_REGS (NUM_REGS),
    .SP_INDEX (SP_INDEX),
    .SP_RESET (SP_RESET)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (ra_q),
    .raddr_b (opb_q[RW-1:0]),
    .rdata_a (rd_a),
    .rdata_b (rd_b),
    .sp_val  (sp_val)
  );

  // memory port
  always_comb begin
    mem_addr = pc_q;
    unique case (state_q)
      ST_FETCH: mem_addr = pc_q;
      ST_OPA:   mem_addr = pc_q + ADDR_W'(1);
      ST_OPB:   mem_addr = pc_q + ADDR_W'(2);
      ST_EXEC:  mem_addr = (kind == K_POP) ? sp_val : pc_q;
      ST_STACK: mem_addr = (kind == K_PUSH) ? sp_val : pc_q;
      default:  mem_addr = pc_q;
    endcase
  end

  assign mem_we    = (state_q == ST_STACK) && (kind == K_PUSH);
  assign mem_wdata = rd_a;

  // register file write port
  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = ra_q;
    rf_wdata = opb_q;
    if (state_q == ST_EXEC) begin
      unique case (kind)
        K_LDI: begin
          rf_we    = 1'b1;
          rf_wdata = opb_q;
        end
        K_MUL: begin
          rf_we    = 1'b1;
          rf_wdata = mul_lo(rd_a, rd_b);
        end
        K_POP: begin
          rf_we    = 1'b1;
          rf_wdata = mem_rdata;
        end
        K_PUSH: begin
          rf_we    = 1'b1;
          rf_waddr = SP_SEL;
          rf_wdata = sp_dec(sp_val);
        end
        default: rf_we = 1'b0;
      endcase
    end else if ((state_q == ST_STACK) && (kind == K_POP)) begin
      rf_we    = 1'b1;
      rf_waddr = SP_SEL;
      rf_wdata = sp_inc(sp_val);
    end
  end

  // fetch registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      ra_q  <= '0;
      opb_q <= '0;
    end else begin
      if (state_q == ST_FETCH) ir_q  <= mem_rdata;
      if (state_q == ST_OPA)   ra_q  <= mem_rdata[RW-1:0];
      if (state_q == ST_OPB)   opb_q <= mem_rdata;
    end
  end

  // program counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc_q <= '0;
    else if (ev_retire) pc_q <= pc_q + pc_step(ir_q);
  end

  // output strobe and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      halted    <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= (state_q == ST_EXEC) && (kind == K_EMIT);
      if ((state_q == ST_EXEC) && (kind == K_EMIT)) out_data <= rd_a;
      if ((state_q == ST_EXEC) && ir_stops)        halted   <= 1'b1;
      if ((state_q == ST_EXEC) && !ir_legal)       illegal  <= 1'b1;
    end
  end

  assign ev_fetch   = (state_q == ST_FETCH);
  assign ev_retire  = (state_q == ST_EXEC) && !ir_stops;
  assign ev_push_wr = mem_we;
  assign ev_pop_rd  = (state_q == ST_EXEC) && (kind == K_POP);

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk
  import cpu8_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_fetch,
  input logic              ev_retire,
  input logic              ev_push_wr,
  input logic              ev_pop_rd,
  input logic [ADDR_W-1:0] pc_q,
  input logic [WORD_W-1:0] ir_q,
  input logic [WORD_W-1:0] sp_val,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              out_valid,
  input logic              halted,
  input logic              illegal
);

  a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    ev_retire |=> pc_q == $past(pc_q) + pc_step($past(ir_q)));

  a_r4_emit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r6_push_after_dec: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_wr |-> (mem_addr == sp_val) && (sp_val == $past(sp_val) - 8'd1));

  a_r7_pop_at_sp: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_rd |-> mem_addr == sp_val);

  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  a_r8_quiet_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ev_fetch && !mem_we && !ev_retire);

  a_r9_illegal_halts: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);

endmodule

bind cpu8_core cpu8_core_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_fetch   (ev_fetch),
  .ev_retire  (ev_retire),
  .ev_push_wr (ev_push_wr),
  .ev_pop_rd  (ev_pop_rd),
  .pc_q       (pc_q),
  .ir_q       (ir_q),
  .sp_val     (sp_val),
  .mem_addr   (mem_addr),
  .mem_we     (mem_we),
  .out_valid  (out_valid),
  .halted     (halted),
  .illegal    (illegal)
);

// File: tb/cpu8_core_tb_top.sv
module cpu8_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, out_data;
  logic       mem_we, out_valid, halted, illegal;

  logic [7:0] ram [256];
  logic [7:0] exp_q [$];
  int         checks = 0;
  int         errors = 0;
  int         ld_ptr = 0;
  string      cur_req = "R4";

  always #10 clk = ~clk;   // 50 MHz

  cpu8_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_rdata (mem_rdata),
    .out_valid (out_valid),
    .out_data  (out_data),
    .halted    (halted),
    .illegal   (illegal)
  );

  assign mem_rdata = ram[mem_addr];

  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // monitor: compares emitted values with the scoreboard, watches halt rules
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check({cur_req, " unexpected emit"}, int'(out_data), -1);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        check({cur_req, " emit value"}, int'(out_data), int'(e));
      end
    end
    if (rst_n && halted && mem_we) check("R8 write after halt", 1, 0);
  end

  // driver helpers
  task automatic begin_prog(input string req);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    ld_ptr  = 0;
    cur_req = req;
    exp_q.delete();
  endtask

  task automatic put(input logic [7:0] b);
    ram[ld_ptr] = b;
    ld_ptr++;
  endtask

  task automatic expect_emit(input logic [7:0] v);
    exp_q.push_back(v);
  endtask

  task automatic run_prog(input logic exp_illegal);
    logic [7:0] a0;
    int n;
    // R1: state while reset is held
    check("R1 reset halted", int'(halted), 0);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset fetch address", int'(mem_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({cur_req, " reached halt"}, int'(halted), 1);
    check(exp_illegal ? "R9 illegal flag" : "R8 illegal flag clear",
          int'(illegal), int'(exp_illegal));
    a0 = mem_addr;
    repeat (10) @(negedge clk);
    check("R8 halted sticky", int'(halted), 1);
    check("R8 address frozen", int'(mem_addr), int'(a0));
    check({cur_req, " all emits seen"}, exp_q.size(), 0);
  endtask

  initial begin
    // R1/R3/R4: load, emit, stack pointer reset value
    begin_prog("R3");
    put(8'h82); put(8'h00); put(8'h08);
    put(8'h47); put(8'h00);
    put(8'h47); put(8'h07);
    put(8'h01);
    expect_emit(8'h08);
    expect_emit(8'hF4);        // R1: register 7 reset value
    run_prog(1'b0);

    // R5: multiply, truncated and exact
    begin_prog("R5");
    put(8'h82); put(8'h00); put(8'd200);
    put(8'h82); put(8'h01); put(8'd3);
    put(8'hA2); put(8'h00); put(8'h01);
    put(8'h47); put(8'h00);
    put(8'h82); put(8'h02); put(8'd15);
    put(8'h82); put(8'h03); put(8'd17);
    put(8'hA2); put(8'h02); put(8'h03);
    put(8'h47); put(8'h02);
    put(8'h47); put(8'h03);
    put(8'h01);
    expect_emit(8'd88);        // 600 mod 256
    expect_emit(8'd255);
    expect_emit(8'd17);        // rB unchanged
    run_prog(1'b0);

    // R6/R7: push/pop ordering from reset stack pointer
    begin_prog("R6");
    put(8'h82); put(8'h00); put(8'h11);
    put(8'h45); put(8'h00);
    put(8'h82); put(8'h00); put(8'h22);
    put(8'h45); put(8'h00);
    put(8'h46); put(8'h01);
    put(8'h46); put(8'h02);
    put(8'h47); put(8'h01);
    put(8'h47); put(8'h02);
    put(8'h47); put(8'h07);
    put(8'h01);
    expect_emit(8'h22);        // R7: last pushed pops first
    expect_emit(8'h11);
    expect_emit(8'hF4);        // R7: pointer restored
    run_prog(1'b0);
    check("R6 first push at 0xF3", int'(ram[8'hF3]), 8'h11);
    check("R6 second push at 0xF2", int'(ram[8'hF2]), 8'h22);

    // R6/R7: stack pointer wrap at zero
    begin_prog("R7");
    put(8'h82); put(8'h07); put(8'h00);
    put(8'h82); put(8'h01); put(8'h5A);
    put(8'h45); put(8'h01);
    put(8'h47); put(8'h07);
    put(8'h46); put(8'h02);
    put(8'h47); put(8'h02);
    put(8'h47); put(8'h07);
    put(8'h01);
    expect_emit(8'hFF);        // R6: 0x00 - 1 wraps
    expect_emit(8'h5A);
    expect_emit(8'h00);        // R7: 0xFF + 1 wraps
    run_prog(1'b0);
    check("R6 wrapped push at 0xFF", int'(ram[8'hFF]), 8'h5A);

    // R10: upper bits of register operand ignored
    begin_prog("R10");
    put(8'h82); put(8'h09); put(8'h77);   // selects register 1
    put(8'h47); put(8'hF9);               // also register 1
    put(8'h47); put(8'h01);
    put(8'h01);
    expect_emit(8'h77);
    expect_emit(8'h77);
    run_prog(1'b0);

    // R9: unknown opcode stops the core, later emit never runs
    begin_prog("R9");
    put(8'h82); put(8'h00); put(8'h05);
    put(8'h47); put(8'h00);
    put(8'h03);
    put(8'h47); put(8'h00);
    put(8'h01);
    expect_emit(8'h05);
    run_prog(1'b1);

    // R2: stop opcode needs no operands; emit right after reset
    begin_prog("R2");
    put(8'h47); put(8'h07);
    put(8'h01);
    put(8'h47); put(8'h07);
    expect_emit(8'hF4);
    run_prog(1'b0);

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule